// File: doc/BRIEF.md
# Single-Slot Posted-Write Memory Arbiter

This block controls access to main memory from the bus side of a host bridge. Bus masters reach it through a target port. A write burst is captured into a buffer that holds one posted write: one base address and a small beat store. The bus sees each beat completed as soon as the block takes it, before any of the data has reached memory. The captured burst is then drained to memory one beat per cycle.

Only one write can be held at a time. A new write, or any read, that arrives while that buffer is still occupied is refused with a retry, so reads can never pass the posted write. The processor-to-bus master path has absolute priority over memory. While the `cpu_busy` input is high, the block issues no memory read or write at all. It still captures incoming write beats, because capturing a beat does not touch memory.

A burst longer than the beat store is cut off with a stop indication on the last beat that fits. Target reads are single-beat. A target read is forwarded to memory only when the buffer is empty and the master path is idle.

Top module: `posted_wr_arb`

## Requirements
- R1: After reset, `pw_busy` is 0, `mem_we` and `mem_re` are 0, and with no request, `tgt_ack`, `tgt_retry` and `tgt_stop` are 0.
- R2: While the buffer is empty, every beat of a write burst (`tgt_req`=1, `tgt_we`=1) gets `tgt_ack`=1 in the cycle it is presented, whatever the value of `cpu_busy`. `pw_busy` is 1 from the cycle after the first beat. No memory access happens while beats are being captured.
- R3: If a burst reaches DEPTH beats without `tgt_last`, the DEPTH-th beat is acknowledged together with `tgt_stop`=1. No more than DEPTH beats are ever stored.
- R4: Once capture has ended (after the beat with `tgt_last`, or the stop beat), any new write request gets `tgt_retry`=1 and `tgt_ack`=0 until the buffer has drained. A refused write does not change the drained addresses or data.
- R5: Draining presents beat i (counting from 0) at `mem_addr` = base + i with its captured data on `mem_wdata`. It advances one beat in each cycle in which `mem_rdy`=1 and `cpu_busy`=0.
- R6: While `cpu_busy` is 1, `mem_we` and `mem_re` are 0.
- R7: `pw_busy` stays 1 until the last beat's memory write is accepted, and reads 0 from the next cycle on.
- R8: A target read (`tgt_req`=1, `tgt_we`=0) while `pw_busy`=1 or `cpu_busy`=1 gets `tgt_retry`=1, `tgt_ack`=0, and `mem_re`=0.
- R9: A target read with the buffer empty and `cpu_busy`=0 drives `mem_re`=1 and `mem_addr`=`tgt_addr`. When `mem_rdy`=1 it returns `tgt_ack`=1 and `tgt_rdata`=`mem_rdata` in the same cycle. When `mem_rdy`=0 both `tgt_ack` and `tgt_retry` are 0 (wait state).
- R10: A drain beat that is not accepted (`mem_rdy`=0 or `cpu_busy`=1) keeps the same address and data for the next attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_busy | input | 1 | Processor master transaction in progress |
| tgt_req | input | 1 | Target request / beat valid |
| tgt_we | input | 1 | 1 = write, 0 = read |
| tgt_addr | input | AW | Burst base address or read address |
| tgt_wdata | input | DW | Write beat data |
| tgt_last | input | 1 | Final beat of the write burst |
| tgt_ack | output | 1 | Beat or read completed this cycle |
| tgt_retry | output | 1 | Request refused; master must retry later |
| tgt_stop | output | 1 | Acknowledged beat was the last that fits |
| tgt_rdata | output | DW | Read data |
| pw_busy | output | 1 | Posted-write buffer occupied |
| mem_we | output | 1 | Memory write request |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdy | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Memory read data, valid with `mem_rdy` |

## Verification
Acknowledge, retry, stop, the read path and the memory request lines are all combinational from the current inputs and state. The bench therefore drives inputs at the falling edge and checks these outputs one time unit later, in the same cycle. `pw_busy` is registered. It is checked one cycle after the first accepted beat, and one cycle after the rising edge that accepts the last drain beat. The bench counts drain progress only in cycles where it drove `mem_rdy` high and `cpu_busy` low. That count gives the address and data expected in each following cycle.

// File: rtl/posted_wr_arb.sv
module posted_wr_arb #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_busy,
  input  logic          tgt_req,
  input  logic          tgt_we,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_wdata,
  input  logic          tgt_last,
  output logic          tgt_ack,
  output logic          tgt_retry,
  output logic          tgt_stop,
  output logic [DW-1:0] tgt_rdata,
  output logic          pw_busy,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rdy,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_CAP, S_DRN} st_t;

  st_t           st;
  logic [AW-1:0] base;
  logic [CW-1:0] wcnt;
  logic [IW-1:0] ridx;
  logic [DW-1:0] beats [DEPTH];

  logic acc_wr, full_nxt, rd_go, drn_acc, drn_last;

  assign acc_wr    = tgt_req & tgt_we & (st != S_DRN);
  assign full_nxt  = (wcnt == CW'(DEPTH - 1));
  assign rd_go     = tgt_req & ~tgt_we & (st == S_IDLE) & ~cpu_busy;

  assign tgt_ack   = acc_wr | (rd_go & mem_rdy);
  assign tgt_stop  = acc_wr & full_nxt & ~tgt_last;
  assign tgt_retry = tgt_req & ((st == S_DRN) | (~tgt_we & ((st != S_IDLE) | cpu_busy)));
  assign tgt_rdata = mem_rdata;
  assign pw_busy   = (st != S_IDLE);

  assign mem_re    = rd_go;
  assign mem_we    = (st == S_DRN) & ~cpu_busy;
  assign mem_addr  = rd_go ? tgt_addr : base + AW'(ridx);
  assign mem_wdata = beats[ridx];
  assign drn_acc   = mem_we & mem_rdy;
  assign drn_last  = drn_acc & (CW'(ridx) == wcnt - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      base <= '0;
      wcnt <= '0;
      ridx <= '0;
    end else if (acc_wr) begin
      if (st == S_IDLE) base <= tgt_addr;
      wcnt <= wcnt + CW'(1);
      st   <= (tgt_last | full_nxt) ? S_DRN : S_CAP;
    end else if (drn_last) begin
      st   <= S_IDLE;
      wcnt <= '0;
      ridx <= '0;
    end else if (drn_acc) begin
      ridx <= ridx + IW'(1);
    end
  end

  always_ff @(posedge clk)
    if (acc_wr) beats[wcnt[IW-1:0]] <= tgt_wdata;

  a_r6_cpu_excl: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_busy |-> !(mem_we || mem_re));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CW'(DEPTH));

  a_r4_retry_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRN && tgt_req) |-> (tgt_retry && !tgt_ack));

  a_r7_clear_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    drn_last |=> !pw_busy);

  a_r2_busy_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_ack && tgt_we) |=> pw_busy);

  a_r8_read_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_we && (pw_busy || cpu_busy)) |-> (tgt_retry && !tgt_ack && !mem_re));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_rdy && !tgt_ack) |=> (mem_addr == $past(mem_addr)));
endmodule

// File: tb/sim_posted_wr_arb.sv
module sim_posted_wr_arb;
  localparam int AW = 12, DW = 16, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_busy = 0, tgt_req = 0, tgt_we = 0, tgt_last = 0, mem_rdy = 0;
  logic [AW-1:0] tgt_addr = '0;
  logic [DW-1:0] tgt_wdata = '0;
  logic tgt_ack, tgt_retry, tgt_stop, pw_busy, mem_we, mem_re;
  logic [DW-1:0] tgt_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign mem_rdata = {mem_addr[7:0], ~mem_addr[7:0]};

  posted_wr_arb #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy), .tgt_req(tgt_req), .tgt_we(tgt_we),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_last(tgt_last), .tgt_ack(tgt_ack),
    .tgt_retry(tgt_retry), .tgt_stop(tgt_stop), .tgt_rdata(tgt_rdata), .pw_busy(pw_busy),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] bdata(int len, int b);
    return DW'(len * 256 + b * 17 + 3);
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk(pw_busy == 0 && mem_we == 0 && mem_re == 0, "R1 reset", pw_busy, 0);
    chk(!tgt_ack && !tgt_retry && !tgt_stop, "R1 idle resp", tgt_ack, 0);
    rst_n = 1;

    for (int len = 1; len <= DEPTH + 2; len++) begin
      for (int v = 0; v < 2; v++) begin
        logic [AW-1:0] base;
        int n, i, cyc;
        base = AW'(len * 32 + v * 8);
        n = (len < DEPTH) ? len : DEPTH;
        for (int b = 0; b < n; b++) begin
          @(negedge clk);
          cpu_busy = v[0]; mem_rdy = 1;
          tgt_req = 1; tgt_we = 1; tgt_addr = base; tgt_wdata = bdata(len, b);
          tgt_last = (b == len - 1);
          #1;
          chk(tgt_ack && !tgt_retry, "R2 beat ack", tgt_ack, 1);
          chk(tgt_stop == (b == DEPTH - 1 && len > DEPTH), "R3 stop", tgt_stop, int'(b == DEPTH - 1 && len > DEPTH));
          chk(pw_busy == (b != 0), "R2 pw_busy", pw_busy, int'(b != 0));
          chk(!mem_we && !mem_re, "R2 no mem in capture", mem_we, 0);
        end
        i = 0; cyc = 0;
        while (i < n && cyc < 200) begin
          logic exp_w;
          @(negedge clk);
          cpu_busy = v[0] ? (cyc % 3 == 1) : 1'b0;
          mem_rdy = (cyc % 4 != 2);
          tgt_req = (cyc % 2 == 0); tgt_we = (cyc % 4 == 0);
          tgt_addr = 12'h0F0; tgt_wdata = 16'hDEAD; tgt_last = 1;
          #1;
          exp_w = !cpu_busy;
          chk(mem_we == exp_w, "R6 mem_we vs cpu_busy", mem_we, exp_w);
          chk(!mem_re, "R6/R8 no read in drain", mem_re, 0);
          if (exp_w) begin
            chk(mem_addr == base + AW'(i), "R5/R10 drain addr", mem_addr, base + AW'(i));
            chk(mem_wdata == bdata(len, i), "R4/R5 drain data", mem_wdata, bdata(len, i));
          end
          if (tgt_req)
            chk(tgt_retry && !tgt_ack, tgt_we ? "R4 write retried" : "R8 read retried", tgt_retry, 1);
          chk(pw_busy, "R7 busy during drain", pw_busy, 1);
          if (exp_w && mem_rdy) i++;
          cyc++;
        end
        @(negedge clk);
        tgt_req = 0; cpu_busy = 0; mem_rdy = 1;
        #1;
        chk(pw_busy == 0, "R7 cleared", pw_busy, 0);
        chk(!mem_we, "R7 no extra write", mem_we, 0);

        tgt_req = 1; tgt_we = 0; tgt_addr = base + AW'(len);
        #1;
        chk(mem_re && mem_addr == tgt_addr, "R9 read addr", mem_addr, tgt_addr);
        chk(tgt_ack && !tgt_retry && tgt_rdata == {tgt_addr[7:0], ~tgt_addr[7:0]},
            "R9 read data", tgt_rdata, {tgt_addr[7:0], ~tgt_addr[7:0]});
        @(negedge clk);
        mem_rdy = 0;
        #1;
        chk(mem_re && !tgt_ack && !tgt_retry, "R9 wait state", tgt_ack, 0);
        @(negedge clk);
        mem_rdy = 1; cpu_busy = 1;
        #1;
        chk(tgt_retry && !tgt_ack && !mem_re, "R8 read vs cpu_busy", tgt_retry, 1);
        @(negedge clk);
        tgt_req = 0; cpu_busy = 0;
      end
    end
    done = 1;
    summary();
  end
endmodule